// File: doc/BRIEF.md
# Blanking-Period Control Formatter

This block reshapes a parallel pixel stream made of a data-enable bit, vertical and horizontal sync bits and a data word. The output has the form a serial video link expects. While the enable is high (active video), the data word passes through, and the two sync outputs stay frozen at the values they carried on the final blanking pixel. While the enable is low (blanking), the sync bits pass through and the data word is cleared. A programmable set of side-channel bits is the exception: those bits may carry arbitrary payload across blanking, but they are silenced on the opening and closing pixel of every blanking interval.

Deciding whether a blanking pixel closes its interval needs the enable of the following pixel. Every pixel is therefore held in a lookahead register for one clock before the registered output stage formats it. A width select picks a 32-bit or a 24-bit data word. A separate monitor watches the raw enable input for runs that are shorter than the legal minimum and raises a sticky error flag when it finds one.

Top module: `blank_ctl_formatter`

## Requirements
- R1: In wide mode (`wide_i`=1), a pixel with enable high appears on `data_o` with all 32 bits unchanged.
- R2: For a blanking pixel that is neither the first nor the last of its interval, `data_o` equals `data_i & side_mask_i`, with the width limit of R6 applied. Every bit whose mask bit is 0 is low.
- R3: On the first and on the last pixel of each blanking interval, `data_o` is all zero whatever the mask. The first enable-low pixel after reset counts as a first pixel.
- R4: Throughout active video, `vs_o` and `hs_o` hold the sync values of the last blanking pixel before the enable rose, and ignore `vs_i`/`hs_i`. Both are 0 if no blanking pixel has passed since reset.
- R5: For blanking pixels, `vs_o` and `hs_o` equal that pixel's `vs_i` and `hs_i`.
- R6: In narrow mode (`wide_i`=0), bits 31..24 of `data_o` are always 0. This holds in active video and for side-channel bits whose mask bits are set above bit 23.
- R7: A run of constant `de_i` that starts and ends with a change of `de_i` after reset, and lasts fewer than MIN_RUN (2) cycles, sets `run_err_o`. The flag is set after the clock edge that samples the change ending the run. Runs of exactly MIN_RUN cycles never set it. The flag stays set until it is cleared.
- R8: `run_err_o` is cleared by reset or by `err_clr_i` high at a clock edge. A violation detected at the same edge wins over the clear.
- R9: A pixel sampled at rising edge n appears on `de_o`, `vs_o`, `hs_o` and `data_o` right after edge n+1. Its `run_err_o` effect is visible from edge n onward.
- R10: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_i | input | 1 | Data enable, high in active video |
| vs_i | input | 1 | Vertical sync in |
| hs_i | input | 1 | Horizontal sync in |
| data_i | input | 32 | Colour and extra data bits |
| wide_i | input | 1 | 1: 32-bit word, 0: 24-bit word |
| side_mask_i | input | 32 | Bits allowed to carry payload during blanking |
| err_clr_i | input | 1 | Clears the sticky run-length error |
| de_o | output | 1 | Data enable out |
| vs_o | output | 1 | Vertical sync out |
| hs_o | output | 1 | Horizontal sync out |
| data_o | output | 32 | Formatted data word |
| run_err_o | output | 1 | Sticky short-run error |

## Verification
The bench drives each pixel on a falling edge. The enable, sync and data results of that pixel are due after the second rising edge that follows, while its effect on the error flag is already due after the first rising edge. The driver tags every expected item with the number of the edge after which it is due. The monitor samples one nanosecond after each rising edge and compares only the items whose tag matches the current edge count. The model closes a pixel's expected data only once the next pixel's enable is known, and the error value it records is the one that follows that next pixel's sampling edge.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
  typedef struct packed {
    logic de;
    logic vs;
    logic hs;
  } pix_ctl_t;

  function automatic logic [31:0] low_ones(input int unsigned n);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/bcf_lookahead.sv
module bcf_lookahead
  import bcf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_i,
  input  logic          vs_i,
  input  logic          hs_i,
  input  logic [DW-1:0] data_i,
  output pix_ctl_t      ctl_q,
  output logic [DW-1:0] data_q,
  output logic          vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      ctl_q  <= '{de: de_i, vs: vs_i, hs: hs_i};
      data_q <= data_i;
      vld_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/bcf_shaper.sv
module bcf_shaper
  import bcf_pkg::*;
#(
  parameter int DW = 32,
  parameter int NW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  pix_ctl_t      ctl_q,
  input  logic [DW-1:0] data_q,
  input  logic          vld_q,
  input  logic          nxt_de,
  input  logic          wide_i,
  input  logic [DW-1:0] mask_i,
  output logic          de_o,
  output logic          vs_o,
  output logic          hs_o,
  output logic [DW-1:0] data_o
);
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic          armed;
  logic [DW-1:0] width_mask;
  logic [DW-1:0] blank_keep;
  logic          edge_pix;

  always_comb begin
    width_mask = wide_i ? '1 : NARROW_MASK;
    edge_pix   = armed | nxt_de;
    blank_keep = edge_pix ? '0 : (mask_i & width_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o   <= 1'b0;
      vs_o   <= 1'b0;
      hs_o   <= 1'b0;
      data_o <= '0;
      armed  <= 1'b1;
    end else if (vld_q) begin
      de_o  <= ctl_q.de;
      armed <= ctl_q.de;
      if (ctl_q.de) begin
        data_o <= data_q & width_mask;
      end else begin
        data_o <= data_q & blank_keep;
        vs_o   <= ctl_q.vs;
        hs_o   <= ctl_q.hs;
      end
    end else begin
      de_o   <= 1'b0;
      data_o <= '0;
    end
  end

  AST_BLANK_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ctl_q.de && armed) |=> (data_o == '0)); // R3
  AST_BLANK_LAST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ctl_q.de && nxt_de) |=> (data_o == '0)); // R3
  AST_BLANK_UNMASKED_LOW: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ctl_q.de) |=> ((data_o & ~$past(mask_i)) == '0)); // R2
  AST_ACTIVE_SYNC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (de_o && $past(de_o)) |-> ($stable(vs_o) && $stable(hs_o))); // R4
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!wide_i) |-> (data_o[DW-1:NW] == '0)); // R6
endmodule

// File: rtl/bcf_runchk.sv
module bcf_runchk #(
  parameter int MIN_RUN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic de_i,
  input  logic clr_i,
  output logic err_o
);
  localparam int CW = $clog2(MIN_RUN + 1);

  logic          seen;
  logic          last_de;
  logic          bounded;
  logic [CW-1:0] run_len;
  logic          toggle;
  logic          short_run;

  always_comb begin
    toggle    = seen && (de_i != last_de);
    short_run = toggle && bounded && (run_len < CW'(MIN_RUN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      last_de <= 1'b0;
      bounded <= 1'b0;
      run_len <= '0;
      err_o   <= 1'b0;
    end else begin
      seen    <= 1'b1;
      last_de <= de_i;
      if (toggle) begin
        bounded <= 1'b1;
        run_len <= CW'(1);
      end else if (!seen) begin
        run_len <= CW'(1);
      end else if (run_len < CW'(MIN_RUN)) begin
        run_len <= run_len + CW'(1);
      end
      if (short_run)  err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_i) |=> err_o); // R7
  AST_ERR_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> ($past(de_i) != $past(last_de))); // R7
endmodule

// File: rtl/blank_ctl_formatter.sv
module blank_ctl_formatter
  import bcf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NARROW_W = 24,
  parameter int MIN_RUN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de_i,
  input  logic              vs_i,
  input  logic              hs_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] side_mask_i,
  input  logic              err_clr_i,
  output logic              de_o,
  output logic              vs_o,
  output logic              hs_o,
  output logic [DATA_W-1:0] data_o,
  output logic              run_err_o
);
  pix_ctl_t          ctl_q;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  bcf_lookahead #(.DW(DATA_W)) u_look (
    .clk(clk), .rst(rst), .de_i(de_i), .vs_i(vs_i), .hs_i(hs_i),
    .data_i(data_i), .ctl_q(ctl_q), .data_q(data_q), .vld_q(vld_q)
  );

  bcf_shaper #(.DW(DATA_W), .NW(NARROW_W)) u_shape (
    .clk(clk), .rst(rst), .ctl_q(ctl_q), .data_q(data_q), .vld_q(vld_q),
    .nxt_de(de_i), .wide_i(wide_i), .mask_i(side_mask_i),
    .de_o(de_o), .vs_o(vs_o), .hs_o(hs_o), .data_o(data_o)
  );

  bcf_runchk #(.MIN_RUN(MIN_RUN)) u_run (
    .clk(clk), .rst(rst), .de_i(de_i), .clr_i(err_clr_i), .err_o(run_err_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!de_o && !run_err_o && data_o == '0)); // R10
  AST_DE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $past(vld_q) |-> (de_o == $past(ctl_q.de))); // R9
endmodule

// File: tb/blank_ctl_formatter_test.sv
module blank_ctl_formatter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        de_i = 1'b0, vs_i = 1'b0, hs_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        wide_i = 1'b1;
  logic [31:0] side_mask_i = '0;
  logic        err_clr_i = 1'b0;
  logic        de_o, vs_o, hs_o, run_err_o;
  logic [31:0] data_o;

  always #2 clk = ~clk;

  blank_ctl_formatter uut (
    .clk(clk), .rst(rst), .de_i(de_i), .vs_i(vs_i), .hs_i(hs_i),
    .data_i(data_i), .wide_i(wide_i), .side_mask_i(side_mask_i),
    .err_clr_i(err_clr_i), .de_o(de_o), .vs_o(vs_o), .hs_o(hs_o),
    .data_o(data_o), .run_err_o(run_err_o)
  );

  typedef struct {
    int          due;
    logic        de, vs, hs, err;
    logic [31:0] data;
    string       dtag, stag, etag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0, n_bad = 0, edge_cnt = 0;

  // model state
  bit          m_armed, m_seen, m_last, m_bnd, m_err, m_vs, m_hs;
  int          m_run;
  bit          pend_v;
  logic        p_de, p_vs, p_hs;
  logic [31:0] p_data;

  always @(posedge clk) edge_cnt++;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h (edge %0d)", tag, what, act, exp, edge_cnt);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      while (sbq.size() > 0 && sbq[0].due == edge_cnt) begin
        e = sbq.pop_front();
        chk("R9", "de_o", {31'b0, de_o}, {31'b0, e.de});
        chk(e.dtag, "data_o", data_o, e.data);
        chk(e.stag, "sync", {30'b0, vs_o, hs_o}, {30'b0, e.vs, e.hs});
        chk(e.etag, "run_err_o", {31'b0, run_err_o}, {31'b0, e.err});
      end
    end
  end

  task automatic model_reset();
    m_armed = 1; m_seen = 0; m_last = 0; m_bnd = 0; m_err = 0;
    m_vs = 0; m_hs = 0; m_run = 0; pend_v = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; de_i = 0; vs_i = 0; hs_i = 0; data_i = '0; err_clr_i = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset outputs", {de_o, vs_o, hs_o, run_err_o, data_o[27:0]}, '0);
    chk("R10", "reset data", data_o, '0);
  endtask

  task automatic push_pixel(input bit de, input bit vs, input bit hs, input logic [31:0] d,
                            input bit wide, input logic [31:0] mask, input bit clr);
    bit   set;
    exp_t e;
    logic [31:0] wm;
    @(negedge clk);
    rst = 0; de_i = de; vs_i = vs; hs_i = hs; data_i = d;
    wide_i = wide; side_mask_i = mask; err_clr_i = clr;
    // error model: this pixel is sampled at edge edge_cnt+1
    set = 0;
    if (m_seen && de != m_last) begin
      if (m_bnd && m_run < 2) set = 1;
      m_bnd = 1; m_run = 1;
    end else if (!m_seen) m_run = 1;
    else if (m_run < 2) m_run++;
    m_seen = 1; m_last = de;
    if (set) m_err = 1; else if (clr) m_err = 0;
    if (pend_v) begin
      wm = wide ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
      e.due = edge_cnt + 1;
      e.de = p_de;
      e.err = m_err;
      e.etag = clr ? "R8" : "R7";
      if (p_de) begin
        e.data = p_data & wm;
        e.dtag = wide ? "R1" : "R6";
        e.vs = m_vs; e.hs = m_hs; e.stag = "R4";
      end else begin
        if (m_armed || de) begin
          e.data = '0; e.dtag = "R3";
        end else begin
          e.data = p_data & mask & wm; e.dtag = wide ? "R2" : "R6";
        end
        m_vs = p_vs; m_hs = p_hs;
        e.vs = p_vs; e.hs = p_hs; e.stag = "R5";
      end
      m_armed = p_de;
      sbq.push_back(e);
    end
    p_de = de; p_vs = vs; p_hs = hs; p_data = d; pend_v = 1;
  endtask

  task automatic run_seg(input bit de, input int len, input bit wide, input logic [31:0] mask, input int clr_pct);
    for (int i = 0; i < len; i++)
      push_pixel(de, 1'($urandom), 1'($urandom), $urandom, wide, mask, int'($urandom % 100) < clr_pct);
  endtask

  task automatic drain();
    repeat (2) run_seg(1'b0, 1, 1'b1, 32'h0, 0);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    bit lvl;
    bit w;
    logic [31:0] mk;
    do_reset();
    // R1 R2 R3 R4 R5: wide mode, legal runs
    lvl = 0;
    for (int r = 0; r < 40; r++) begin
      run_seg(lvl, 2 + int'($urandom % 5), 1'b1, 32'h00F0_0F0F, 0);
      lvl = ~lvl;
    end
    // R6: narrow mode with mask bits above 23
    for (int r = 0; r < 40; r++) begin
      run_seg(lvl, 2 + int'($urandom % 5), 1'b0, 32'hFF00_00FF, 0);
      lvl = ~lvl;
    end
    // R7: runs of exactly the minimum length
    for (int r = 0; r < 30; r++) begin
      run_seg(lvl, 2, 1'b1, 32'hFFFF_FFFF, 0);
      lvl = ~lvl;
    end
    // R7: one illegal single-cycle run, then R8 clear
    run_seg(lvl, 3, 1'b1, 32'hFFFF_FFFF, 0); lvl = ~lvl;
    run_seg(lvl, 1, 1'b1, 32'hFFFF_FFFF, 0); lvl = ~lvl;
    run_seg(lvl, 6, 1'b1, 32'hFFFF_FFFF, 0);
    push_pixel(lvl, 1'b0, 1'b1, 32'h1234_5678, 1'b1, 32'hFFFF_FFFF, 1'b1);
    run_seg(lvl, 3, 1'b1, 32'hFFFF_FFFF, 0); lvl = ~lvl;
    // R8: violation coinciding with clear
    run_seg(lvl, 1, 1'b1, 32'hFFFF_FFFF, 0); lvl = ~lvl;
    push_pixel(lvl, 1'b1, 1'b0, 32'hCAFE_F00D, 1'b1, 32'hFFFF_FFFF, 1'b1);
    run_seg(lvl, 4, 1'b1, 32'hFFFF_FFFF, 0); lvl = ~lvl;
    // mixed random runs, lengths 1..4, random clears
    for (int r = 0; r < 400; r++) begin
      w  = 1'($urandom);
      mk = $urandom;
      run_seg(lvl, 1 + int'($urandom % 4), w, mk, 12);
      lvl = ~lvl;
    end
    drain();
    // R3 R10: reset mid-stream, first blanking pixel after reset
    run_seg(1'b1, 3, 1'b1, 32'hFFFF_FFFF, 0);
    do_reset();
    run_seg(1'b0, 4, 1'b1, 32'hFFFF_FFFF, 0);
    run_seg(1'b1, 3, 1'b1, 32'hFFFF_FFFF, 0);
    run_seg(1'b0, 3, 1'b1, 32'hFFFF_FFFF, 0);
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule